// File: doc/BRIEF.md
# Operand Address Resolver

This unit takes one memory-reference instruction of a small 24-bit teaching machine, in either its 3-byte short form or its 4-byte long form. It also takes the current program counter and the base and index registers. From these it works out where the operand lives. A caller presents a request and the unit accepts it in one cycle. Some time later it raises a single-cycle done strobe, together with one of the following:

- a 20-bit target address;
- an immediate operand, flagged as such;
- a target address found through one extra memory read;
- an error flag for a flag combination that is not allowed.

The instruction arrives left-aligned in a 32-bit field. Bits 31:26 hold the opcode and are ignored. The six mode flags sit in bits 25:20, in this order: n=25, i=24, x=23, b=22, p=21, e=20. For the short form, bits 19:8 hold a 12-bit displacement and bits 7:0 are unused. For the long form (e=1), bits 19:0 hold a 20-bit address.

The n and i flags select the operand class:

| n | i | Class |
|---|---|-------|
| 1 | 1 | plain address |
| 0 | 1 | immediate |
| 1 | 0 | indirect |
| 0 | 0 | legacy 15-bit direct |

For an indirect request, the unit holds a read request on a simple memory port until the port acknowledges. The low 20 bits of the returned word become the result. All address arithmetic wraps modulo 2^20.

Top module: `operand_addr_unit`

## Requirements
- R1: During and right after reset, reqReady is 1, and doneValid and memReq are 0.
- R2: With (n,i) not 00, e=0, b=1 and p=0, the address is base[19:0] plus the 12-bit displacement taken as unsigned, mod 2^20.
- R3: With (n,i) not 00, e=0, b=0 and p=1, the address is pcCur+3 plus the displacement sign-extended from bit 11, mod 2^20.
- R4: With (n,i) not 00, e=0 and b=p=0, the address is the zero-extended displacement. With e=1, it is instr[19:0], and b and p are ignored.
- R5: When x=1 in a legal mode, index[19:0] is added to the address, mod 2^20.
- R6: Immediate mode (n=0, i=1, x=0) returns the address with resImm=1. It makes no memory request, and doneValid rises in the cycle after acceptance.
- R7: Indirect mode (n=1, i=0, x=0) requests a read at the address and holds memReq and memAddr steady until memAck. It then returns memData[19:0] with doneValid in the cycle after the ack.
- R8: Legacy mode (n=0, i=0) uses instr[22:8] (b, p, e and the displacement) as a 15-bit zero-extended address, plus the index when x=1.
- R9: x=1 with immediate or indirect mode, or b=p=1 with e=0 outside legacy mode, sets resErr=1 with doneValid one cycle after acceptance and no memory request.
- R10: doneValid is a one-cycle pulse. reqReady stays 0 from acceptance through the done cycle, and a request raised while busy is ignored and produces no second result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle; request accepted when both high |
| instr | input | 32 | Instruction, opcode in bits 31:26 |
| pcCur | input | 20 | Address of the current instruction |
| baseReg | input | 24 | Base register contents |
| indexReg | input | 24 | Index register contents |
| memReq | output | 1 | Read request for indirect fetch |
| memAddr | output | 20 | Read address |
| memAck | input | 1 | Read data valid, one cycle |
| memData | input | 24 | Read word |
| doneValid | output | 1 | Result valid, one cycle |
| resAddr | output | 20 | Target address or immediate operand |
| resImm | output | 1 | Result is an immediate operand |
| resErr | output | 1 | Illegal mode combination |

## Verification
A wrong mode decode shows up in the first done cycle after acceptance, as a wrong address, a wrong immediate or error flag, or a memory request that should not occur. The bench sweeps all 64 flag patterns against displacements at both sign edges and register values near the top of the address space. This exposes wrap and sign-extension slips in the same transaction. A control state that sticks in the fetch phase or skips it shows within a few cycles, as a missing or extra done pulse, or as a result that does not match the word the bench model returned.

// File: rtl/oau_pkg.sv
package oau_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic loadTa;
    logic loadInd;
  } ctlStrobe_t;
endpackage

// File: rtl/oau_datapath.sv
module oau_datapath
  import oau_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 24,
  parameter int DISPW = 12,
  parameter int IW    = AW + 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] pcCur,
  input  logic [DW-1:0] baseReg,
  input  logic [DW-1:0] indexReg,
  input  logic [DW-1:0] memData,
  input  ctlStrobe_t    strobe,
  output logic          modeImm,
  output logic          modeInd,
  output logic          modeErr,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] resAddr,
  output logic          resImm,
  output logic          resErr
);
  // flag positions sit just above the address field
  localparam int EPOS = AW;
  localparam int PPOS = AW + 1;
  localparam int BPOS = AW + 2;
  localparam int XPOS = AW + 3;
  localparam int IPOS = AW + 4;
  localparam int NPOS = AW + 5;
  localparam int LOWB = AW - DISPW;
  localparam int LEGW = DISPW + 3;

  logic fN, fI, fX, fB, fP, fE;
  logic [DISPW-1:0] disp;
  logic [AW-1:0] dispU, dispS, legAddr, pcNext, baseSum, ixAdd, ta;

  assign fN = instr[NPOS];
  assign fI = instr[IPOS];
  assign fX = instr[XPOS];
  assign fB = instr[BPOS];
  assign fP = instr[PPOS];
  assign fE = instr[EPOS];
  assign disp = instr[AW-1:LOWB];

  assign dispU   = {{(AW-DISPW){1'b0}}, disp};
  assign dispS   = {{(AW-DISPW){disp[DISPW-1]}}, disp};
  assign legAddr = {{(AW-LEGW){1'b0}}, instr[BPOS:LOWB]};
  assign pcNext  = pcCur + AW'(3);
  assign ixAdd   = fX ? indexReg[AW-1:0] : '0;

  always_comb begin
    if (!fN && !fI) begin
      baseSum = legAddr;
    end else if (fE) begin
      baseSum = instr[AW-1:0];
    end else begin
      case ({fB, fP})
        2'b10:   baseSum = baseReg[AW-1:0] + dispU;
        2'b01:   baseSum = pcNext + dispS;
        default: baseSum = dispU;
      endcase
    end
  end

  assign ta      = baseSum + ixAdd;
  assign modeImm = !fN && fI;
  assign modeInd = fN && !fI;
  assign modeErr = (fX && (modeImm || modeInd)) ||
                   ((fN || fI) && !fE && fB && fP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAddr <= '0;
      resImm  <= 1'b0;
      resErr  <= 1'b0;
    end else if (strobe.loadTa) begin
      resAddr <= modeErr ? '0 : ta;
      resImm  <= modeImm && !modeErr;
      resErr  <= modeErr;
    end else if (strobe.loadInd) begin
      resAddr <= memData[AW-1:0];
    end
  end

  assign memAddr = resAddr;
endmodule

// File: rtl/oau_control.sv
module oau_control
  import oau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       modeInd,
  input  logic       modeErr,
  input  logic       memAck,
  output logic       reqReady,
  output logic       memReq,
  output logic       doneValid,
  output ctlStrobe_t strobe
);
  ctlState_t state, stateNext;
  logic accept;

  assign reqReady  = (state == ST_IDLE);
  assign accept    = reqValid && reqReady;
  assign memReq    = (state == ST_FETCH);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    stateNext      = state;
    strobe.loadTa  = 1'b0;
    strobe.loadInd = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        strobe.loadTa = 1'b1;
        stateNext = (modeInd && !modeErr) ? ST_FETCH : ST_DONE;
      end
      ST_FETCH: if (memAck) begin
        strobe.loadInd = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/operand_addr_unit.sv
module operand_addr_unit
  import oau_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DW    = 24,
  parameter int DISPW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AW+11:0]   instr,
  input  logic [AW-1:0]    pcCur,
  input  logic [DW-1:0]    baseReg,
  input  logic [DW-1:0]    indexReg,
  output logic             memReq,
  output logic [AW-1:0]    memAddr,
  input  logic             memAck,
  input  logic [DW-1:0]    memData,
  output logic             doneValid,
  output logic [AW-1:0]    resAddr,
  output logic             resImm,
  output logic             resErr
);
  ctlStrobe_t strobe;
  logic modeImm, modeInd, modeErr;

  oau_datapath #(.AW(AW), .DW(DW), .DISPW(DISPW), .IW(AW + 12)) u_dp (
    .clk(clk), .rstN(rstN), .instr(instr), .pcCur(pcCur),
    .baseReg(baseReg), .indexReg(indexReg), .memData(memData),
    .strobe(strobe), .modeImm(modeImm), .modeInd(modeInd),
    .modeErr(modeErr), .memAddr(memAddr), .resAddr(resAddr),
    .resImm(resImm), .resErr(resErr)
  );

  oau_control u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeInd(modeInd),
    .modeErr(modeErr), .memAck(memAck), .reqReady(reqReady),
    .memReq(memReq), .doneValid(doneValid), .strobe(strobe)
  );
endmodule

// File: rtl/oau_checker.sv
module oau_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic          memAck,
  input logic          doneValid,
  input logic          resImm,
  input logic          resErr
);
  // R1
  always @(posedge clk) begin
    if (!rstN) reset_idle_chk: assert (!memReq && !doneValid && reqReady);
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || doneValid) |-> !reqReady);

  // R7
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R7
  ack_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> (doneValid && !resErr && !resImm));

  // R7
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(reqValid && reqReady));

  // R6
  imm_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && resImm) |-> $past(reqValid && reqReady));

  // R9
  err_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && resErr) |-> $past(reqValid && reqReady));
endmodule

bind operand_addr_unit oau_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
  .doneValid(doneValid), .resImm(resImm), .resErr(resErr)
);

// File: tb/operand_addr_unit_test.sv
module operand_addr_unit_test;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] instr = '0;
  logic [19:0] pcCur = '0;
  logic [23:0] baseReg = '0, indexReg = '0;
  logic memReq, memAck;
  logic [19:0] memAddr;
  logic [23:0] memData;
  logic doneValid, resImm, resErr;
  logic [19:0] resAddr;

  int total = 0;
  int bad = 0;
  int memCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  operand_addr_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .instr(instr), .pcCur(pcCur), .baseReg(baseReg), .indexReg(indexReg),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .doneValid(doneValid), .resAddr(resAddr), .resImm(resImm), .resErr(resErr)
  );

  function automatic logic [23:0] memWord(input logic [19:0] a);
    memWord = ({4'h0, a} * 24'd13) + 24'h2A5C1;
  endfunction

  // memory model: acknowledges after MEM_LAT cycles of request
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      if (memCnt == MEM_LAT - 1) begin
        memAck  <= 1'b1;
        memData <= memWord(memAddr);
        memCnt  <= 0;
      end else begin
        memCnt <= memCnt + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end
  initial begin
    memAck  = 1'b0;
    memData = '0;
  end

  task automatic check(input bit ok, input string tag, input logic [23:0] act,
                       input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic runOne(input logic [5:0] flags, input logic [11:0] disp,
                        input logic [7:0] lowB, input logic [19:0] pc,
                        input logic [23:0] bReg, input logic [23:0] xReg,
                        input bit inject);
    logic n, i, x, b, p, e;
    logic [19:0] ta, expAddr;
    bit isImm, isInd, isErr, sawMem, done, injected;
    logic [19:0] seenAddr;
    int lat;
    {n, i, x, b, p, e} = flags;
    isImm = !n && i;
    isInd = n && !i;
    isErr = (x && (isImm || isInd)) || ((n || i) && !e && b && p);
    if (!n && !i) ta = {5'b0, b, p, e, disp};
    else if (e)   ta = {disp, lowB};
    else if (b && !p) ta = bReg[19:0] + {8'h0, disp};
    else if (!b && p) ta = pc + 20'd3 + {{8{disp[11]}}, disp};
    else ta = {8'h0, disp};
    if (x) ta = ta + xReg[19:0];
    expAddr = isInd ? memWord(ta)[19:0] : ta;

    @(negedge clk);
    instr    = {6'h2B, flags, disp, lowB};
    pcCur    = pc;
    baseReg  = bReg;
    indexReg = xReg;
    reqValid = 1'b1;
    sawMem = 0; done = 0; injected = 0; lat = 0; seenAddr = '0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      reqValid = 1'b0;
      if (memReq) begin
        sawMem = 1;
        seenAddr = memAddr;
        if (inject && !injected) begin
          // R10: request while busy must be ignored
          instr = ~instr;
          reqValid = 1'b1;
          injected = 1;
        end
      end
      if (doneValid) done = 1;
      else check(!reqReady, "R10 ready low while busy", {23'h0, reqReady}, 24'h0);
    end
    check(done, "R10 done seen", {23'h0, done}, 24'h1);
    check(resErr == isErr, "R9 error flag", {23'h0, resErr}, {23'h0, isErr});
    if (isErr) begin
      check(!sawMem, "R9 no memory request", {23'h0, sawMem}, 24'h0);
      check(lat == 1, "R9 latency", lat, 1);
    end else begin
      check(resAddr == expAddr,
            isInd ? "R7 indirect result" : (!n && !i) ? "R8 legacy address" :
            x ? "R5 indexed address" : e ? "R4 extended address" :
            (b ? "R2 base address" : p ? "R3 pc address" : "R4 direct address"),
            {4'h0, resAddr}, {4'h0, expAddr});
      check(resImm == isImm, "R6 immediate flag", {23'h0, resImm}, {23'h0, isImm});
      check(sawMem == isInd, "R6 R7 memory use", {23'h0, sawMem}, {23'h0, isInd});
      if (isInd) check(seenAddr == ta, "R7 fetch address", {4'h0, seenAddr}, {4'h0, ta});
      else check(lat == 1, "R6 latency", lat, 1);
    end
    @(negedge clk);
    reqValid = 1'b0;
    check(!doneValid && reqReady, "R10 single pulse and idle",
          {22'h0, doneValid, reqReady}, 24'h1);
  endtask

  initial begin
    logic [11:0] dispSet [6];
    dispSet = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF, 12'h5A3};
    repeat (3) @(negedge clk);
    check(reqReady && !doneValid && !memReq, "R1 during reset",
          {21'h0, reqReady, doneValid, memReq}, 24'h4);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !doneValid && !memReq, "R1 after reset",
          {21'h0, reqReady, doneValid, memReq}, 24'h4);
    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int f = 0; f < 64; f++) begin
        for (int d = 0; d < 6; d++) begin
          if (cfg == 0)
            runOne(6'(f), dispSet[d], 8'h3C ^ dispSet[d][7:0], 20'h00100,
                   24'h000FF0, 24'h000010, 1'b0);
          else
            runOne(6'(f), dispSet[d], 8'hC3 ^ dispSet[d][7:0], 20'hFFFFE,
                   24'hFFFFFA, 24'h0FFFF8, 1'b1);
        end
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule